// File: doc/BRIEF.md
# Framebuffer-to-LCD Refresh Streamer

This block is a bus master on the host side. It copies a complete monochrome frame, held in a synchronous framebuffer memory, into a page-addressed display controller. The controller sits on an 8-bit parallel bus of the 80-series kind, with a write strobe, an active-low chip select and a data/command select line. One `start_i` pulse runs one refresh. If `reset_req_i` is high with that pulse, the refresh begins with a timed hardware reset of the display. It then sends a display-on command. For every page, in ascending order, it sends a page-select command and a two-byte column-zero command, followed by the row of pixel bytes for that page.

The controller moves its column pointer forward on its own only inside a page. For that reason the streamer sends the page and column address again at the start of every page. Framebuffer byte `k` belongs to page `k / COLS` and column `k % COLS`. The streamer puts each framebuffer address on the read port while the previous byte is still on the display bus, so the next byte is ready as soon as the bus is free. When the refresh is complete, `done_o` pulses for one clock.

Top module: `lcd_refresh_streamer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `lcd_cs_n_o`, `lcd_wr_n_o` and `lcd_rst_n_o` are 1 and `done_o` and `busy_o` are 0. This also holds when `rst` is raised in the middle of a refresh or during the display reset pulse.
- R2: When `start_i` comes with `reset_req_i`=1, `lcd_rst_n_o` goes low for exactly RST_CYCLES (16) clocks. At least RST_CYCLES more clocks then pass with chip select high before the first bus write. When `reset_req_i`=0, `lcd_rst_n_o` stays high.
- R3: The first byte written in a refresh is the display-on command 0xAF, sent with `lcd_dc_o`=0.
- R4: For each page p from 0 to PAGES-1 (4), the streamer writes three commands with `lcd_dc_o`=0: 0xB0|p, then 0x10, then 0x00. It then writes COLS (128) bytes with `lcd_dc_o`=1.
- R5: Pixel byte c of page p equals framebuffer byte p*COLS+c, read through the one-cycle-latency port `fb_addr_o`/`fb_data_i`.
- R6: A refresh writes exactly 1 + PAGES*(3+COLS) = 525 bytes.
- R7: In each write, `lcd_wr_n_o` is low for exactly one clock, with `lcd_cs_n_o` low. `lcd_data_o` and `lcd_dc_o` stay stable from the cycle before the strobe to the cycle after it. Chip select is never low while `busy_o` is 0.
- R8: `done_o` is high for exactly one clock, two clocks after the strobe of the last pixel byte. `busy_o` falls in that same cycle.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The refresh still writes 525 bytes, `done_o` pulses once, and no extra display reset pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock request to begin a refresh |
| reset_req_i | input | 1 | With `start_i`: pulse the display reset first |
| fb_addr_o | output | 9 | Framebuffer read address (byte index) |
| fb_data_i | input | 8 | Framebuffer read data, valid one clock after the address |
| lcd_cs_n_o | output | 1 | Display chip select, active low |
| lcd_dc_o | output | 1 | 0 = command byte, 1 = pixel byte |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rst_n_o | output | 1 | Display hardware reset, active low |
| lcd_data_o | output | 8 | Display data bus |
| done_o | output | 1 | One-clock pulse at the end of a refresh |
| busy_o | output | 1 | High while a refresh is in progress |

## Verification
The assertions check the shape of each bus cycle on every clock: the one-clock strobe, chip select held low under it, data and data/command held steady around it, and no request to the bus writer while it is busy. They also check that the display reset is only low while the streamer is busy, that done lasts a single clock in the idle state, and that a start during a refresh never re-enters the reset phase. Only the bench scenarios can show the byte order: the display-on, page and column commands, the framebuffer bytes in order, and the total of 525. The same holds for the exact reset and wait lengths, the placement of done after the last strobe, and recovery from a reset raised mid-refresh.

// File: rtl/lcd_stream_pkg.sv
package lcd_stream_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_DISPLAY_ON = 8'hAF;
  localparam logic [BYTE_W-1:0] CMD_PAGE_BASE  = 8'hB0;
  localparam logic [BYTE_W-1:0] CMD_COL_HI     = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_COL_LO     = 8'h00;

  typedef enum logic [1:0] {
    WR_IDLE, WR_SETUP, WR_STROBE, WR_HOLD
  } wr_state_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RST_LO, SQ_RST_WAIT, SQ_ON, SQ_PAGE, SQ_COL_HI, SQ_COL_LO, SQ_DATA
  } sq_state_e;
endpackage

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
  import lcd_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              req_dc_i,
  input  logic [BYTE_W-1:0] req_data_i,
  output logic              ack_o,
  output logic              cs_n_o,
  output logic              dc_o,
  output logic              wr_n_o,
  output logic [BYTE_W-1:0] data_o
);
  wr_state_e state;

  // ack is taken straight from the state register: high during the hold phase
  assign ack_o = (state == WR_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WR_IDLE;
      cs_n_o <= 1'b1;
      wr_n_o <= 1'b1;
      dc_o   <= 1'b0;
      data_o <= '0;
    end else begin
      case (state)
        WR_IDLE: if (req_i) begin
          cs_n_o <= 1'b0;
          wr_n_o <= 1'b1;
          dc_o   <= req_dc_i;
          data_o <= req_data_i;
          state  <= WR_SETUP;
        end
        WR_SETUP: begin
          wr_n_o <= 1'b0;
          state  <= WR_STROBE;
        end
        WR_STROBE: begin
          wr_n_o <= 1'b1;
          state  <= WR_HOLD;
        end
        default: begin
          cs_n_o <= 1'b1;
          state  <= WR_IDLE;
        end
      endcase
    end
  end

  // R7: the strobe lasts exactly one clock
  assert_strobe_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |=> wr_n_o);
  // R7: chip select is low under the strobe
  assert_cs_under_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> !cs_n_o);
  // R7: data and command select are set up before the strobe
  assert_setup_before_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> ($stable(data_o) && $stable(dc_o)));
  // R7: data and command select are held after the strobe
  assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |=> ($stable(data_o) && $stable(dc_o)));
  // R7: the sequencer only requests while the writer is idle
  assert_no_req_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    req_i |-> (state == WR_IDLE));
endmodule

// File: rtl/lcd_refresh_seq.sv
module lcd_refresh_seq
  import lcd_stream_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int COLS       = 128,
  parameter int RST_CYCLES = 16,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int ADDR_W = COL_W + PAGE_W,
  localparam int CNT_W  = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              reset_req_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [BYTE_W-1:0] fb_data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              req_dc_o,
  output logic [BYTE_W-1:0] req_data_o,
  output logic              lcd_rst_n_o,
  output logic              done_o,
  output logic              busy_o
);
  sq_state_e         state;
  logic              issued;
  logic [ADDR_W-1:0] idx;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page;
  logic              col_last, page_last, byte_state, cnt_last;

  assign page       = idx[ADDR_W-1:COL_W];
  assign col_last   = (idx[COL_W-1:0] == COL_W'(COLS - 1));
  assign page_last  = (page == PAGE_W'(PAGES - 1));
  assign cnt_last   = (cnt == CNT_W'(RST_CYCLES - 1));
  assign byte_state = (state == SQ_ON) || (state == SQ_PAGE) || (state == SQ_COL_HI) ||
                      (state == SQ_COL_LO) || (state == SQ_DATA);
  assign req_o      = byte_state && !issued;
  assign busy_o     = (state != SQ_IDLE);

  always_comb begin
    req_dc_o   = 1'b0;
    req_data_o = CMD_DISPLAY_ON;
    case (state)
      SQ_PAGE:   req_data_o = CMD_PAGE_BASE | {{(BYTE_W-PAGE_W){1'b0}}, page};
      SQ_COL_HI: req_data_o = CMD_COL_HI;
      SQ_COL_LO: req_data_o = CMD_COL_LO;
      SQ_DATA: begin
        req_dc_o   = 1'b1;
        req_data_o = fb_data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      issued      <= 1'b0;
      idx         <= '0;
      cnt         <= '0;
      fb_addr_o   <= '0;
      lcd_rst_n_o <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        SQ_IDLE: if (start_i) begin
          idx    <= '0;
          cnt    <= '0;
          issued <= 1'b0;
          if (reset_req_i) begin
            lcd_rst_n_o <= 1'b0;
            state       <= SQ_RST_LO;
          end else begin
            state <= SQ_ON;
          end
        end
        SQ_RST_LO: begin
          if (cnt_last) begin
            cnt         <= '0;
            lcd_rst_n_o <= 1'b1;
            state       <= SQ_RST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_RST_WAIT: begin
          if (cnt_last) begin
            cnt   <= '0;
            state <= SQ_ON;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (req_o) begin
            issued <= 1'b1;
            // prefetch: address goes out while the current byte is on the bus
            if (state == SQ_COL_LO) fb_addr_o <= idx;
            if (state == SQ_DATA)   fb_addr_o <= idx + 1'b1;
          end else if (ack_i) begin
            issued <= 1'b0;
            case (state)
              SQ_ON:     state <= SQ_PAGE;
              SQ_PAGE:   state <= SQ_COL_HI;
              SQ_COL_HI: state <= SQ_COL_LO;
              SQ_COL_LO: state <= SQ_DATA;
              default: begin
                idx <= idx + 1'b1;
                if (col_last) begin
                  if (page_last) begin
                    state  <= SQ_IDLE;
                    done_o <= 1'b1;
                  end else begin
                    state <= SQ_PAGE;
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  // R2: the display reset is only driven low inside a refresh
  assert_rst_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n_o |-> busy_o);
  // R8: done is a single-clock pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: done coincides with the return to idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R9: a start while streaming bytes never re-enters the reset phase
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (byte_state && start_i) |=> (state != SQ_RST_LO) && (state != SQ_RST_WAIT));
endmodule

// File: rtl/lcd_refresh_streamer.sv
module lcd_refresh_streamer
  import lcd_stream_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int COLS       = 128,
  parameter int RST_CYCLES = 16,
  localparam int ADDR_W = $clog2(COLS) + $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              reset_req_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [BYTE_W-1:0] fb_data_i,
  output logic              lcd_cs_n_o,
  output logic              lcd_dc_o,
  output logic              lcd_wr_n_o,
  output logic              lcd_rst_n_o,
  output logic [BYTE_W-1:0] lcd_data_o,
  output logic              done_o,
  output logic              busy_o
);
  logic              req, req_dc, ack;
  logic [BYTE_W-1:0] req_data;

  lcd_refresh_seq #(
    .PAGES(PAGES), .COLS(COLS), .RST_CYCLES(RST_CYCLES)
  ) seq_i (
    .clk(clk), .rst(rst), .start_i(start_i), .reset_req_i(reset_req_i),
    .fb_addr_o(fb_addr_o), .fb_data_i(fb_data_i), .ack_i(ack),
    .req_o(req), .req_dc_o(req_dc), .req_data_o(req_data),
    .lcd_rst_n_o(lcd_rst_n_o), .done_o(done_o), .busy_o(busy_o)
  );

  lcd_bus_writer writer_i (
    .clk(clk), .rst(rst), .req_i(req), .req_dc_i(req_dc), .req_data_i(req_data),
    .ack_o(ack), .cs_n_o(lcd_cs_n_o), .dc_o(lcd_dc_o), .wr_n_o(lcd_wr_n_o),
    .data_o(lcd_data_o)
  );

  // R7: chip select stays high whenever no refresh is running
  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> lcd_cs_n_o);
endmodule

// File: tb/lcd_refresh_streamer_tb.sv
`timescale 1ns/1ps
module lcd_refresh_streamer_tb_top;
  localparam int PAGES = 4, COLS = 128, RSTC = 16;
  localparam int NBYTES = 1 + PAGES * (3 + COLS);

  logic clk = 0, rst = 1, start = 0, rreq = 0;
  logic [8:0] fb_addr;
  logic [7:0] fb_rd, lcd_data;
  logic cs_n, dc, wr_n, lrst_n, done, busy;

  always #10 clk = ~clk;

  lcd_refresh_streamer #(.PAGES(PAGES), .COLS(COLS), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .reset_req_i(rreq),
    .fb_addr_o(fb_addr), .fb_data_i(fb_rd),
    .lcd_cs_n_o(cs_n), .lcd_dc_o(dc), .lcd_wr_n_o(wr_n), .lcd_rst_n_o(lrst_n),
    .lcd_data_o(lcd_data), .done_o(done), .busy_o(busy)
  );

  logic [7:0] fb [PAGES*COLS];
  always @(posedge clk) fb_rd <= fb[fb_addr];

  function automatic logic [7:0] fbval(int k, logic [7:0] s);
    return 8'(k * (2 * s + 1)) ^ 8'(k >> 7) ^ s;
  endfunction

  // vector: {reset_req, seed[7:0], start_mid_run, expected reset-low clocks[5:0]}
  localparam int NV = 4;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 8'h00, 1'b0, 6'd16},
    {1'b0, 8'h5A, 1'b0, 6'd0},
    {1'b1, 8'hC3, 1'b1, 6'd16},
    {1'b0, 8'h17, 1'b1, 6'd0}
  };

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus monitor, sampled at the falling edge
  int nb, rst_low, pre_cs, done_cnt, done_cyc, last_strb, width_err, idle_err, cyc;
  bit seen_rst, seen_cs, prev_low;
  logic [7:0] cap_d [600];
  logic       cap_dc [600];

  task automatic clear_mon();
    nb = 0; rst_low = 0; pre_cs = 0; done_cnt = 0; done_cyc = 0; last_strb = 0;
    width_err = 0; idle_err = 0; seen_rst = 0; seen_cs = 0; prev_low = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!wr_n) begin
        if (prev_low) width_err++;
        if (nb < 600) begin
          cap_d[nb] = lcd_data;
          cap_dc[nb] = dc;
        end
        nb++;
        last_strb = cyc;
      end
      prev_low = !wr_n;
      if (!lrst_n) begin
        rst_low++;
        seen_rst = 1;
      end else if (seen_rst && !seen_cs && cs_n) pre_cs++;
      if (!cs_n) seen_cs = 1;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (!busy && !cs_n) idle_err++;
    end
  end

  task automatic check_idle(string what);
    chk(cs_n === 1'b1 && wr_n === 1'b1 && lrst_n === 1'b1, "R1", {what, " bus lines"},
        {cs_n, wr_n, lrst_n}, 7);
    chk(done === 1'b0 && busy === 1'b0, "R1", {what, " done/busy"}, {done, busy}, 0);
  endtask

  task automatic run_vec(logic rr, logic [7:0] s, logic mid, int exp_rst);
    int cmd_bad, dat_bad, j;
    for (int k = 0; k < PAGES*COLS; k++) fb[k] = fbval(k, s);
    @(posedge clk); #1;
    clear_mon();
    start = 1; rreq = rr;
    @(posedge clk); #1;
    start = 0; rreq = 0;
    if (mid) begin
      repeat (150) @(posedge clk);
      #1 start = 1; rreq = 1;
      @(posedge clk); #1 start = 0; rreq = 0;
    end
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(posedge clk);
    repeat (40) @(posedge clk);
    #1;
    chk(nb == NBYTES, "R6", "bytes written", nb, NBYTES);
    chk(cap_d[0] == 8'hAF && cap_dc[0] == 1'b0, "R3", "display-on first",
        {cap_dc[0], cap_d[0]}, 8'hAF);
    cmd_bad = 0; dat_bad = 0; j = 1;
    for (int p = 0; p < PAGES; p++) begin
      if (cap_d[j] != (8'hB0 | 8'(p)) || cap_dc[j]) cmd_bad++;
      if (cap_d[j+1] != 8'h10 || cap_dc[j+1]) cmd_bad++;
      if (cap_d[j+2] != 8'h00 || cap_dc[j+2]) cmd_bad++;
      j += 3;
      for (int c = 0; c < COLS; c++) begin
        if (!cap_dc[j]) cmd_bad++;
        if (cap_d[j] != fbval(p*COLS + c, s)) dat_bad++;
        j++;
      end
    end
    chk(cmd_bad == 0, "R4", "page/column commands and dc", cmd_bad, 0);
    chk(dat_bad == 0, "R5", "pixel bytes vs framebuffer", dat_bad, 0);
    chk(rst_low == exp_rst, "R2", "reset low clocks", rst_low, exp_rst);
    if (rr) chk(pre_cs >= RSTC, "R2", "wait after reset", pre_cs, RSTC);
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    chk(done_cyc - last_strb == 2, "R8", "done after last strobe", done_cyc - last_strb, 2);
    chk(width_err == 0, "R7", "strobe width errors", width_err, 0);
    chk(idle_err == 0, "R7", "cs low while idle", idle_err, 0);
    if (mid) chk(nb == NBYTES && done_cnt == 1, "R9", "start while busy ignored",
                 nb, NBYTES);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check_idle("after reset");

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][15], VEC[v][14:7], VEC[v][6], int'(VEC[v][5:0]));

    // directed: reset raised mid-refresh during pixel streaming
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    repeat (300) @(posedge clk);
    #1 rst = 1;
    @(posedge clk); @(negedge clk);
    check_idle("reset mid-refresh");
    @(posedge clk); #1 rst = 0;

    // directed: reset raised while the display reset pulse is low
    @(posedge clk); #1 start = 1; rreq = 1;
    @(posedge clk); #1 start = 0; rreq = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(lrst_n === 1'b0, "R2", "display reset low mid-pulse", lrst_n, 0);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); @(negedge clk);
    check_idle("reset during reset pulse");
    @(posedge clk); #1 rst = 0;

    // a full refresh still works after the aborts
    run_vec(1'b1, 8'h3C, 1'b0, RSTC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule